// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

A purely combinational 32-bit arithmetic and logic unit for the execute stage of a load-store RISC core. It receives a 4-bit operation code, a first operand taken from the register file and a second operand that has already passed through the shifter. It also receives the current N, Z, C and V flags, the shifter's carry-out and a set-flags control. From these it computes a 32-bit result, a write-enable for that result and the next value of each flag. Because it has no registers, the outputs follow the inputs within the same cycle.

The unit handles several groups of operations. The move operations pass the second operand or its bitwise inverse. The add and subtract operations come with and without an incoming carry. The reverse-subtract operations swap the operand order. The bitwise operations are AND, OR, XOR and bit-clear. The compare and test operations compute a value only to set the flags and never write a register. In subtraction the carry flag means "no borrow", so an add followed by an add-with-carry, or a subtract followed by a subtract-with-carry, chains correctly across words. No data stream passes through the block, so it has no valid/ready handshake. All pins are plain control and data levels.

Top module: `dp_alu`

## Requirements
- R1: Operation code 13 (move) gives result = op2. Operation code 15 (move-inverted) gives result = bitwise NOT of op2.
- R2: Operation code 4 gives op1+op2 and code 5 gives op1+op2+C. With the set-flags control asserted, C becomes the carry out of bit 31.
- R3: Operation code 2 gives op1-op2 and code 6 gives op1-op2-(1-C). C becomes 1 when no borrow occurs and 0 when a borrow occurs, so 5-3 gives C=1 and 3-5 gives C=0.
- R4: Operation code 3 gives op2-op1 and code 7 gives op2-op1-(1-C). The carry follows the same no-borrow rule as R3.
- R5: Operation code 0 is AND, 1 is XOR, 12 is OR and 14 is bit-clear (op1 AND NOT op2). For example, 0x11111111 bit-cleared with 0x01100101 gives 0x10011010.
- R6: Codes 8 (test, AND), 9 (test-equal, XOR), 10 (compare, op1-op2) and 11 (compare-inverted, op1+op2) drive the write-enable low. All other codes drive it high.
- R7: With the set-flags control low, all four next flags equal the current flags.
- R8: With set-flags high, N is bit 31 of the computed value and Z is 1 exactly when that value is zero. For the bitwise, move and test codes, C takes the shifter carry-out and V keeps its current value.
- R9: With set-flags high on an arithmetic code (2-7, 10, 11), V is 1 exactly when the signed result of the operation performed falls outside the 32-bit signed range.
- R10: An add with flags set on the low words, followed by an add-with-carry on the high words using the carry produced, gives the exact 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select (encoding in R1-R6) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted |
| cur_n | input | 1 | Current negative flag |
| cur_z | input | 1 | Current zero flag |
| cur_c | input | 1 | Current carry flag |
| cur_v | input | 1 | Current overflow flag |
| shift_carry | input | 1 | Carry-out from the shifter |
| set_flags | input | 1 | Update the flags when high |
| result | output | 32 | Computed value |
| result_we | output | 1 | Result is to be written to a register |
| next_n | output | 1 | Next negative flag |
| next_z | output | 1 | Next zero flag |
| next_c | output | 1 | Next carry flag |
| next_v | output | 1 | Next overflow flag |

## Verification
The checker evaluates several properties every time the inputs change. It confirms that the compare and test codes never raise the write-enable and that a low set-flags control passes all four flags through unchanged. It confirms that N and Z track the computed value whenever flags are set. It also confirms that the bitwise and move codes take C from the shifter and leave V untouched. The exact arithmetic values, the no-borrow carry, signed overflow and the 64-bit chain depend on operand values, so only the bench's reference model can show them. The bench exercises these with random operands and with directed corner cases.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_arith(input alu_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_writes(input alu_op_e op);
    return op[3:2] != 2'b10;
  endfunction
endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic           cout,
  output logic           ovf
);
  localparam int MSB = W - 1;
  logic [W-1:0] x, y;
  logic         ci;
  logic [W:0]   wide;

  // All eight arithmetic forms reduce to x + y + ci on one adder.
  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1; end
      OP_SBC:         begin y = ~b; ci = cin;  end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
      OP_RSC:         begin x = b; y = ~a; ci = cin;  end
      OP_ADC:         ci = cin;
      default:        ci = 1'b0;
    endcase
  end

  assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] arith_val,
  input  logic         arith_c,
  input  logic         arith_v,
  input  logic [W-1:0] logic_val,
  input  nzcv_t        cur,
  input  logic         shift_c,
  input  logic         set_flags,
  output logic [W-1:0] value,
  output logic         we,
  output nzcv_t        nxt
);
  logic arith;
  assign arith = op_is_arith(op);
  assign value = arith ? arith_val : logic_val;
  assign we    = op_writes(op);

  always_comb begin
    nxt = cur;
    if (set_flags) begin
      nxt.n = value[W-1];
      nxt.z = (value == '0);
      nxt.c = arith ? arith_c : shift_c;
      nxt.v = arith ? arith_v : cur.v;
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         cur_n,
  input  logic         cur_z,
  input  logic         cur_c,
  input  logic         cur_v,
  input  logic         shift_carry,
  input  logic         set_flags,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         next_n,
  output logic         next_z,
  output logic         next_c,
  output logic         next_v
);
  alu_op_e      op;
  logic [W-1:0] sum_w, log_w;
  logic         cout_w, ovf_w;
  nzcv_t        cur_w, nxt_w;

  assign op    = alu_op_e'(op_code);
  assign cur_w = '{n: cur_n, z: cur_z, c: cur_c, v: cur_v};

  dp_alu_addsub #(.W(W)) u_addsub (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(cur_c),
    .sum(sum_w), .cout(cout_w), .ovf(ovf_w)
  );

  dp_alu_logic #(.W(W)) u_logic (
    .op(op), .a(opnd_a), .b(opnd_b), .y(log_w)
  );

  dp_alu_flags #(.W(W)) u_flags (
    .op(op), .arith_val(sum_w), .arith_c(cout_w), .arith_v(ovf_w),
    .logic_val(log_w), .cur(cur_w), .shift_c(shift_carry),
    .set_flags(set_flags), .value(result), .we(result_we), .nxt(nxt_w)
  );

  assign next_n = nxt_w.n;
  assign next_z = nxt_w.z;
  assign next_c = nxt_w.c;
  assign next_v = nxt_w.v;
endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int W = 32
) (
  input logic [3:0]   op_code,
  input logic         cur_n,
  input logic         cur_z,
  input logic         cur_c,
  input logic         cur_v,
  input logic         shift_carry,
  input logic         set_flags,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic         next_n,
  input logic         next_z,
  input logic         next_c,
  input logic         next_v
);
  logic is_logical;
  assign is_logical = (op_code inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15});

  always_comb begin
    // R6: compare/test codes never request a register write
    if (op_code[3:2] == 2'b10)
      a_r6_cmp_no_write: assert (!result_we);
    else
      a_r6_other_write: assert (result_we);
    // R7: flags pass through when not updating
    if (!set_flags)
      a_r7_flags_hold: assert ({next_n, next_z, next_c, next_v} == {cur_n, cur_z, cur_c, cur_v});
    // R8: N and Z follow the computed value
    if (set_flags)
      a_r8_nz_track: assert (next_n == result[W-1] && next_z == (result == '0));
    // R8: logical codes take C from the shifter and keep V
    if (set_flags && is_logical)
      a_r8_logic_cv: assert (next_c == shift_carry && next_v == cur_v);
  end
endmodule

bind dp_alu dp_alu_checker #(.W(W)) u_chk (
  .op_code(op_code), .cur_n(cur_n), .cur_z(cur_z), .cur_c(cur_c), .cur_v(cur_v),
  .shift_carry(shift_carry), .set_flags(set_flags), .result(result),
  .result_we(result_we), .next_n(next_n), .next_z(next_z), .next_c(next_c),
  .next_v(next_v)
);

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        cur_n = 0, cur_z = 0, cur_c = 0, cur_v = 0, shift_carry = 0, set_flags = 0;
  logic [31:0] result;
  logic        result_we, next_n, next_z, next_c, next_v;
  int          n_tests = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  dp_alu dut_i (.*);

  // Packed expectation: {we, n, z, c, v, value[31:0]}
  function automatic logic [36:0] model(input logic [3:0] op, input logic [31:0] a, b,
      input logic n, z, c, v, sc, sf);
    longint unsigned ua = a, ub = b, x, y, s;
    longint          sx, sy, ss;
    logic [31:0] val;
    logic nc, nv, arith, sub_form, swap, use_c;
    arith = 1; sub_form = 0; swap = 0; use_c = 0;
    case (op)
      4'd4, 4'd11: ;
      4'd5: use_c = 1;
      4'd2, 4'd10: sub_form = 1;
      4'd6: begin sub_form = 1; use_c = 1; end
      4'd3: begin sub_form = 1; swap = 1; end
      4'd7: begin sub_form = 1; swap = 1; use_c = 1; end
      default: arith = 0;
    endcase
    x = swap ? ub : ua;
    y = swap ? ua : ub;
    sx = longint'($signed(swap ? b : a));
    sy = longint'($signed(swap ? a : b));
    nc = sc; nv = v;
    if (arith) begin
      if (sub_form) begin
        s  = x - y - ((use_c && !c) ? 1 : 0);
        ss = sx - sy - ((use_c && !c) ? 1 : 0);
        nc = (x >= y + ((use_c && !c) ? 1 : 0));
      end else begin
        s  = x + y + ((use_c && c) ? 1 : 0);
        ss = sx + sy + ((use_c && c) ? 1 : 0);
        nc = s[32];
      end
      val = s[31:0];
      nv = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    end else begin
      case (op)
        4'd0, 4'd8:  val = a & b;
        4'd1, 4'd9:  val = a ^ b;
        4'd12:       val = a | b;
        4'd13:       val = b;
        4'd14:       val = a & ~b;
        default:     val = ~b;
      endcase
    end
    if (!sf) return {(op < 4'd8 || op > 4'd11), n, z, c, v, val};
    return {(op < 4'd8 || op > 4'd11), val[31], (val == 0), nc, nv, val};
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic sf);
    if (!sf) return "R7";
    case (op)
      4'd13, 4'd15: return "R1";
      4'd4, 4'd5: return "R2";
      4'd2, 4'd6: return "R3";
      4'd3, 4'd7: return "R4";
      4'd8, 4'd9, 4'd10, 4'd11: return "R6";
      4'd0, 4'd1, 4'd12, 4'd14: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check_val(input string req, input logic [63:0] act, exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, b,
      input logic n, z, c, v, sc, sf);
    logic [36:0] e;
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b;
    cur_n = n; cur_z = z; cur_c = c; cur_v = v; shift_carry = sc; set_flags = sf;
    #2;
    e = model(op, a, b, n, z, c, v, sc, sf);
    check_val(tag_of(op, sf), {27'd0, result_we, next_n, next_z, next_c, next_v, result},
              {27'd0, e});
  endtask

  initial begin
    logic [31:0] lo, hi;
    logic        cy;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs, AND code, no flag update
    @(negedge clk); #2;
    check_val("R7 reset", {result_we, next_n, next_z, next_c, next_v, result},
              {1'b1, 4'b0000, 32'd0});
    // R1: move of zero with flags: Z=1, N=0, V kept, C from shifter
    apply(4'd13, 32'h1234, 32'd0, 1, 0, 0, 1, 1, 1);
    check_val("R1 mov Z", {next_n, next_z, next_v, next_c}, 4'b0111);
    apply(4'd15, 32'h0, 32'h0F0F0000, 0, 0, 0, 0, 0, 0);
    check_val("R1 mvn", result, 32'hF0F0FFFF);
    // R5: bit-clear example
    apply(4'd14, 32'h11111111, 32'h01100101, 0, 0, 0, 0, 0, 1);
    check_val("R5 bic", result, 32'h10011010);
    // R3: no-borrow carry
    apply(4'd2, 32'd5, 32'd3, 0, 0, 0, 0, 0, 1);
    check_val("R3 5-3 C", {result, next_c}, {32'd2, 1'b1});
    apply(4'd2, 32'd3, 32'd5, 0, 0, 1, 0, 0, 1);
    check_val("R3 3-5 C", {result, next_c}, {32'hFFFFFFFE, 1'b0});
    // R4: reverse subtract with carry clear => extra borrow
    apply(4'd7, 32'd3, 32'd10, 0, 0, 0, 0, 0, 1);
    check_val("R4 rsc", {result, next_c}, {32'd6, 1'b1});
    // R9: signed overflow
    apply(4'd4, 32'h7FFFFFFF, 32'd1, 0, 0, 0, 0, 0, 1);
    check_val("R9 add ovf", {next_n, next_v, next_c}, 3'b110);
    apply(4'd2, 32'h80000000, 32'd1, 0, 0, 0, 0, 0, 1);
    check_val("R9 sub ovf", {next_v, next_c}, 2'b11);
    // R6: compare writes nothing, still sets Z
    apply(4'd10, 32'd77, 32'd77, 0, 0, 0, 0, 0, 1);
    check_val("R6 cmp", {result_we, next_z, next_c}, 3'b011);
    // R7: no update with set_flags low
    apply(4'd4, 32'hFFFFFFFF, 32'd1, 1, 0, 0, 1, 1, 0);
    check_val("R7 hold", {next_n, next_z, next_c, next_v}, 4'b1001);
    // R10: 64-bit chain
    apply(4'd4, 32'hFFFFFFF0, 32'h00000020, 0, 0, 0, 0, 0, 1);
    lo = result; cy = next_c;
    apply(4'd5, 32'h00000001, 32'h00000002, 0, 0, cy, 0, 0, 1);
    hi = result;
    check_val("R10 chain", {hi, lo}, 64'h00000001FFFFFFF0 + 64'h0000000200000020);
    // R8: logical op takes shifter carry and keeps V
    apply(4'd0, 32'hF0000000, 32'hF0000000, 0, 0, 0, 1, 1, 1);
    check_val("R8 and", {next_n, next_c, next_v}, 3'b111);
    // random sweep, all codes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom(); rb = $urandom();
      if (i % 7 == 0) ra = {ra[31], 31'h7FFFFFFF & {31{ra[0]}}};
      if (i % 11 == 0) rb = ra;
      apply(4'($urandom_range(0, 15)), ra, rb, 1'($urandom()), 1'($urandom()),
            1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule